// File: doc/BRIEF.md
# Fault-Triggered Single-Step Debug Controller

This controller sits beside a processor core. It lets the core run freely until the core reports a fault. A fault is either an opcode with no defined meaning or an access to an address where no memory exists. On the first such fault the controller halts free-running execution and places the core in a step mode that a host drives. Only a reset brings the core back to free-running execution.

In step mode, each strobe from the serial receiver releases one instruction. The release is a single-cycle step pulse to the core. When the core signals that the instruction has retired, the controller captures the core's program counter, bus address, bus data and opcode. It sends them to a byte-wide transmitter through a ready/valid handshake. The receiver byte's value does not matter; only its arrival counts. Strobes that arrive before a stepped instruction has retired and its dump has finished are dropped, not queued.

Top module: `step_debug_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, run_en_o is 1, step_o is 0 and tx_valid_o is 0.
- R2: In run mode, a high fault_opcode_i sampled at a clock edge drives run_en_o to 0 from the cycle after that edge.
- R3: In run mode, a high fault_addr_i sampled at a clock edge drives run_en_o to 0 from the cycle after that edge.
- R4: Once run_en_o is 0 it stays 0 until rst_ni is asserted. Further faults, receiver strobes and retirements have no effect on it.
- R5: In step mode with no instruction or dump outstanding, an rx_strobe_i sampled at an edge raises step_o for exactly the one cycle after that edge.
- R6: After a step pulse, no further step pulse occurs until retire_i has been seen and the following dump has completed.
- R7: The retire_i cycle after a step pulse captures pc_i, addr_i, data_i and opcode_i. The controller then sends 13 bytes in this order: the PC most-significant byte first (4 bytes), then the address (4), then the data (4), then the opcode (1). Input changes after the capture cycle do not alter the bytes. tx_valid_o falls after the last byte is accepted.
- R8: While tx_valid_o is 1 and tx_ready_i is 0, tx_valid_o stays 1 and tx_data_o holds its value. A byte is consumed only on a cycle where both signals are 1.
- R9: rx_strobe_i pulses that arrive while a step pulse, a retirement wait or a dump is outstanding produce no step pulse, either then or later.
- R10: Fault inputs raised in step mode do not start, stop or change a dump.
- R11: In run mode, rx_strobe_i and retire_i produce no step pulse and no transmitted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_opcode_i | input | 1 | Core fetched an undefined opcode |
| fault_addr_i | input | 1 | Core accessed an unmapped address |
| rx_strobe_i | input | 1 | One-cycle pulse per byte received from the host |
| retire_i | input | 1 | Core finished the stepped instruction |
| pc_i | input | 32 | Core program counter |
| addr_i | input | 32 | Core bus address |
| data_i | input | 32 | Core bus data |
| opcode_i | input | 8 | Current opcode |
| run_en_o | output | 1 | Free-running execution enable |
| step_o | output | 1 | One-cycle single-instruction release |
| tx_data_o | output | 8 | Snapshot byte to the transmitter |
| tx_valid_o | output | 1 | tx_data_o holds a byte to send |
| tx_ready_i | input | 1 | Transmitter accepts the byte this cycle |

## Verification
The assertions assume that retire_i is never high in the same cycle as step_o. They also assume that the transmitter only raises tx_ready_i as a plain acknowledgement and never withdraws a byte. The stimulus raises retire_i at least one cycle after each step pulse and computes tx_ready_i from a fixed arithmetic pattern. During the waits for retirement and during dumps, the bench keeps firing receiver strobes and both fault inputs. This shows that the dropped events leave no trace in later pulses or bytes.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_PULSE  = 2'd1,
    SEQ_RETIRE = 2'd2,
    SEQ_DUMP   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dbg_fault_latch.sv
module dbg_fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_opcode_i,
  input  logic fault_addr_i,
  output logic step_mode_o
);
  logic fault_any;
  assign fault_any = fault_opcode_i | fault_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       step_mode_o <= 1'b0;
    else if (!step_mode_o && fault_any) step_mode_o <= 1'b1;
  end

  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_mode_o |=> step_mode_o);
  a_r2_r3_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_mode_o && fault_any) |=> step_mode_o);
endmodule

// File: rtl/dbg_step_seq.sv
module dbg_step_seq
  import dbg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_mode_i,
  input  logic rx_strobe_i,
  input  logic retire_i,
  input  logic ser_busy_i,
  output logic step_o,
  output logic load_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:   if (step_mode_i && rx_strobe_i) state_d = SEQ_PULSE;
      SEQ_PULSE:  state_d = SEQ_RETIRE;
      SEQ_RETIRE: if (retire_i) state_d = SEQ_DUMP;
      SEQ_DUMP:   if (!ser_busy_i) state_d = SEQ_IDLE;
      default:    state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  assign step_o = (state_q == SEQ_PULSE);
  assign load_o = (state_q == SEQ_RETIRE) && retire_i;

  a_r5_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);
  a_r11_no_step_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_mode_i |-> !step_o);
  a_r6_no_retire_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> !retire_i);
endmodule

// File: rtl/dbg_snap_ser.sv
module dbg_snap_ser #(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OP_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              tx_ready_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  output logic              busy_o
);
  localparam int PC_B    = (PC_W + 7) / 8;
  localparam int ADDR_B  = (ADDR_W + 7) / 8;
  localparam int DATA_B  = (DATA_W + 7) / 8;
  localparam int OP_B    = (OP_W + 7) / 8;
  localparam int N_BYTES = PC_B + ADDR_B + DATA_B + OP_B;
  localparam int SNAP_W  = N_BYTES * 8;
  localparam int CNT_W   = $clog2(N_BYTES + 1);

  logic [SNAP_W-1:0] snap_in, shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              take;

  // each field zero-padded to whole bytes, MSB first
  assign snap_in = {(PC_B*8)'(pc_i), (ADDR_B*8)'(addr_i),
                    (DATA_B*8)'(data_i), (OP_B*8)'(op_i)};

  assign tx_valid_o = (cnt_q != '0);
  assign busy_o     = tx_valid_o;
  assign tx_data_o  = shreg_q[SNAP_W-1 -: 8];
  assign take       = tx_valid_o && tx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      shreg_q <= snap_in;
      cnt_q   <= CNT_W'(N_BYTES);
    end else if (take) begin
      shreg_q <= {shreg_q[SNAP_W-9:0], 8'h00};
      cnt_q   <= cnt_q - CNT_W'(1);
    end
  end

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
  a_r7_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o);
  a_r7_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> tx_valid_o);
endmodule

// File: rtl/step_debug_ctrl.sv
module step_debug_ctrl #(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OP_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_opcode_i,
  input  logic              fault_addr_i,
  input  logic              rx_strobe_i,
  input  logic              retire_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [OP_W-1:0]   opcode_i,
  output logic              run_en_o,
  output logic              step_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i
);
  logic step_mode, ser_busy, load;

  dbg_fault_latch u_fault (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .fault_opcode_i (fault_opcode_i),
    .fault_addr_i   (fault_addr_i),
    .step_mode_o    (step_mode)
  );

  dbg_step_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_mode_i (step_mode),
    .rx_strobe_i (rx_strobe_i),
    .retire_i    (retire_i),
    .ser_busy_i  (ser_busy),
    .step_o      (step_o),
    .load_o      (load)
  );

  dbg_snap_ser #(
    .PC_W(PC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OP_W(OP_W)
  ) u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .pc_i       (pc_i),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .op_i       (opcode_i),
    .tx_ready_i (tx_ready_i),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o),
    .busy_o     (ser_busy)
  );

  assign run_en_o = !step_mode;

  a_r4_run_stays_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en_o |=> !run_en_o);
  a_r11_no_tx_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_en_o |-> (!tx_valid_o && !step_o));
  a_r6_no_step_in_dump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !step_o);
endmodule

// File: tb/step_debug_ctrl_bench.sv
module step_debug_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        f_op, f_ad, rx, ret, rdy;
  logic [31:0] pc, ad, da;
  logic [7:0]  op;
  logic        run_en, step, tx_valid;
  logic [7:0]  tx_data;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  step_debug_ctrl u_step_debug_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .fault_opcode_i(f_op), .fault_addr_i(f_ad),
    .rx_strobe_i(rx), .retire_i(ret), .pc_i(pc), .addr_i(ad), .data_i(da),
    .opcode_i(op), .run_en_o(run_en), .step_o(step), .tx_data_o(tx_data),
    .tx_valid_o(tx_valid), .tx_ready_i(rdy)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_step(input int s);
    logic [103:0] snap;
    logic [7:0]   exp_b, prev_d;
    bit           prev_stall;
    int           idx, guard;
    // R5: strobe releases one pulse
    @(negedge clk); rx = 1'b1;
    @(negedge clk); rx = 1'b0;
    chk(step == 1'b1, "R5 pulse", step, 1);
    @(negedge clk);
    chk(step == 1'b0, "R5 width", step, 0);
    // R6 R9 R10: strobes and faults while waiting for retire
    for (int w = 0; w < (s % 3) + 1; w++) begin
      rx = (w == 0); f_op = 1'b1;
      @(negedge clk);
      chk(step == 1'b0, "R6 R9 no pulse before retire", step, 0);
    end
    rx = 1'b0; f_op = 1'b0;
    pc = 32'h1000_0000 + s * 32'h0101_0104;
    ad = 32'hA000_0000 ^ (s * 32'h0001_1111);
    da = 32'h5A5A_0000 + s * 32'h0000_0F0F;
    op = 8'h40 + 8'(s * 7);
    snap = {pc, ad, da, op};
    ret = 1'b1;
    @(negedge clk);
    ret = 1'b0; pc = ~pc; ad = ~ad; da = ~da; op = ~op;
    idx = 0; guard = 0; prev_stall = 0; prev_d = '0;
    while (idx < 13 && guard < 200) begin
      if (prev_stall)
        chk(tx_valid && tx_data == prev_d, "R8 hold", tx_data, prev_d);
      rdy = (s == 0) ? 1'b1 : (((guard + s) % 3) != 0);
      rx = guard[0];
      f_ad = ((guard % 4) == 1);
      chk(step == 1'b0, "R9 no pulse in dump", step, 0);
      if (tx_valid && rdy) begin
        exp_b = 8'(snap >> (8 * (12 - idx)));
        chk(tx_data == exp_b, "R7 R10 byte", tx_data, exp_b);
        idx++;
      end
      prev_stall = tx_valid && !rdy;
      prev_d = tx_data;
      guard++;
      @(negedge clk);
    end
    rdy = 1'b0; rx = 1'b0; f_ad = 1'b0;
    chk(idx == 13, "R7 byte count", idx, 13);
    chk(tx_valid == 1'b0, "R7 valid falls", tx_valid, 0);
    @(negedge clk);
    chk(run_en == 1'b0, "R4 still stepping", run_en, 0);
    chk(step == 1'b0 && tx_valid == 1'b0, "R9 no late pulse", step, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; f_op = 0; f_ad = 0; rx = 0; ret = 0; rdy = 0;
    pc = '0; ad = '0; da = '0; op = '0;
    repeat (3) @(negedge clk);
    chk(run_en && !step && !tx_valid, "R1 in reset", {run_en, step, tx_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(run_en && !step && !tx_valid, "R1 after reset", {run_en, step, tx_valid}, 3'b100);
    // R11: strobes and retire ignored in run mode
    for (int c = 0; c < 6; c++) begin
      rx = c[0]; ret = ~c[0]; rdy = 1'b1;
      @(negedge clk);
      chk(!step && !tx_valid && run_en, "R11 run ignores rx", {run_en, step, tx_valid}, 3'b100);
    end
    rx = 0; ret = 0; rdy = 0;
    // R2
    f_op = 1'b1;
    @(negedge clk); f_op = 1'b0;
    chk(run_en == 1'b0, "R2 opcode fault", run_en, 0);
    repeat (4) @(negedge clk);
    chk(run_en == 1'b0 && !step, "R4 sticky", run_en, 0);
    for (int s = 0; s < 6; s++) do_step(s);
    // R4: reset returns to run
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(run_en == 1'b1, "R4 reset exits step", run_en, 1);
    // R3
    f_ad = 1'b1;
    @(negedge clk); f_ad = 1'b0;
    chk(run_en == 1'b0, "R3 address fault", run_en, 0);
    do_step(6);
    do_step(7);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule